// File: doc/BRIEF.md
# Serial Register Access Master, LSB-First Framing

This block lets on-chip logic read or write single 8-bit registers in an external peripheral over a four-wire serial link. The peripheral has a 14-bit register address space. The user side raises a request strobe together with a read/write select, an address and, for writes, a data byte. The block then runs one complete serial transaction under a single chip-select assertion. When the transaction ends it pulses a completion flag, and for reads it presents the returned byte on a parallel output.

Every transaction is 24 serial bits long. The first 16 bits form a command header. Bit 0 on the wire is the direction flag. Bits 1 to 14 carry the address, lowest address bit first. Bit 15 is a filler bit, driven low. The last 8 bits are the data byte, least significant bit first. On a write the master sends that byte. On a read the master samples the byte from the peripheral and reassembles it into normal bit order. The serial clock idles low. Outgoing data changes on falling edges and incoming data is sampled on rising edges. The serial clock is the system clock divided by an even parameter.

Top module: `lsb_spi_master`

## Requirements
- R1: While reset is asserted, and directly after it, chip select is high, serial clock is low, busy and done are low, and read data is 0x00.
- R2: The first serial bit of every transaction (bit 0) is 1 for a read and 0 for a write.
- R3: Serial bits 1 through 14 carry address bits 0 through 13 in that order.
- R4: Serial bit 15 is driven 0.
- R5: A write is 24 serial clock cycles under one chip-select assertion, and bits 16 to 23 carry write-data bits 0 to 7 in that order.
- R6: A read is 24 serial clock cycles under one chip-select assertion. The master drives 0 on bits 16 to 23. The data line level sampled at the rising edge of serial bit 16+k becomes bit k of the read data.
- R7: The serial clock is low whenever chip select is high. The outgoing data line does not change while the serial clock is high.
- R8: Each serial clock phase lasts CLK_DIV/2 system cycles. Chip select goes low CLK_DIV/2 cycles before the first rising edge and returns high CLK_DIV/2 cycles after the last falling edge.
- R9: A request is taken only when busy is low, and a request raised while busy has no effect. Done is high for exactly one cycle per transaction, in the cycle where chip select returns high and busy falls. A request held high across done starts the next transaction in the following cycle.
- R10: Read data changes only in a done cycle. After a write it keeps its previous value whatever the peripheral drives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, taken when busy_o is low |
| rd_i | input | 1 | 1 = read, 0 = write, sampled with the request |
| addr_i | input | ADDR_W (14) | Register address |
| wdata_i | input | DATA_W (8) | Write data |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W (8) | Last byte read, valid from the done cycle |
| sclk_o | output | 1 | Serial clock, idles low |
| csn_o | output | 1 | Active-low chip select |
| mosi_o | output | 1 | Serial data to peripheral |
| miso_i | input | 1 | Serial data from peripheral |

## Verification
With H = CLK_DIV/2, a request taken at clock edge 0 pulls chip select low right after that edge. The first rising serial edge is due H cycles later. Serial bit b is high from cycle H(2b+1) to cycle 2H(b+1). Done, the return of chip select and the new read data are all due at cycle 49H. The bench's behavioural model counts cycles from the accepting edge and derives every output from that count. Each output is compared on the falling system clock edge, so every registered update has already settled before it is checked.

// File: rtl/lsb_spi_pkg.sv
package lsb_spi_pkg;

  // Transaction phases of the serial master.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,  // chip select high, waiting for a request
    ST_LEAD  = 2'd1,  // chip select low, setup before the first rising edge
    ST_SHIFT = 2'd2,  // serial clock toggling
    ST_TRAIL = 2'd3   // hold after the last falling edge
  } spi_state_e;

endpackage

// File: rtl/lsb_spi_halftick.sv
module lsb_spi_halftick #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);

  generate
    if (HALF <= 1) begin : g_every
      assign tick_o = run_i;
    end else begin : g_count
      localparam int CW = $clog2(HALF);
      localparam logic [CW-1:0] LAST = CW'(HALF - 1);

      logic [CW-1:0] cnt_q, cnt_d;
      logic          cnt_en;

      assign tick_o = run_i && (cnt_q == LAST);

      always_comb begin
        cnt_en = 1'b1;
        if (!run_i || tick_o) cnt_d = '0;
        else                  cnt_d = cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_en) cnt_q <= cnt_d;
      end
    end
  endgenerate

endmodule

// File: rtl/lsb_spi_txshift.sv
module lsb_spi_txshift #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              mosi_o
);

  localparam int FRAME_BITS = ADDR_W + 2 + DATA_W;

  logic [FRAME_BITS-1:0] frame;
  logic [FRAME_BITS-1:0] sr_q, sr_d;
  logic                  sr_en;
  logic [DATA_W-1:0]     payload;

  // Bit 0 of the frame leaves first: flag, address low to high, pad, data.
  assign payload = rd_i ? '0 : wdata_i;
  assign frame   = {payload, 1'b0, addr_i, rd_i};

  always_comb begin
    sr_en = load_i || shift_i;
    if (load_i) sr_d = frame;
    else        sr_d = {1'b0, sr_q[FRAME_BITS-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (sr_en) sr_q <= sr_d;
  end

  assign mosi_o = sr_q[0];

endmodule

// File: rtl/lsb_spi_rxcap.sv
module lsb_spi_rxcap #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_i,
  input  logic              commit_i,
  input  logic              miso_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] sr_q, sr_d;
  logic [DATA_W-1:0] out_q;

  // Bits arrive low first; shifting in at the top leaves bit 0 at the bottom.
  always_comb begin
    if (DATA_W > 1) sr_d = {miso_i, sr_q[DATA_W-1:1]};
    else            sr_d = miso_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr_q <= '0;
    else if (sample_i) sr_q <= sr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        out_q <= '0;
    else if (commit_i) out_q <= sr_q;
  end

  assign rdata_o = out_q;

endmodule

// File: rtl/lsb_spi_ctrl.sv
module lsb_spi_ctrl
  import lsb_spi_pkg::*;
#(
  parameter int FRAME_BITS = 24,
  parameter int HDR_BITS   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic rd_i,
  input  logic tick_i,
  output logic busy_o,
  output logic done_o,
  output logic sclk_o,
  output logic csn_o,
  output logic load_o,
  output logic shift_o,
  output logic sample_o,
  output logic commit_o
);

  localparam int BW = $clog2(FRAME_BITS);
  localparam logic [BW-1:0] LAST_IDX = BW'(FRAME_BITS - 1);
  localparam logic [BW-1:0] DATA_IDX = BW'(HDR_BITS);

  spi_state_e    state_q, state_d;
  logic          sclk_q, sclk_d;
  logic          csn_q, csn_d;
  logic          done_q, done_d;
  logic          rd_q, rd_d;
  logic [BW-1:0] bit_q, bit_d;
  logic          rise;

  always_comb begin
    state_d  = state_q;
    sclk_d   = sclk_q;
    csn_d    = csn_q;
    done_d   = 1'b0;
    rd_d     = rd_q;
    bit_d    = bit_q;
    load_o   = 1'b0;
    shift_o  = 1'b0;
    commit_o = 1'b0;
    rise     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          state_d = ST_LEAD;
          csn_d   = 1'b0;
          rd_d    = rd_i;
          bit_d   = '0;
          load_o  = 1'b1;
        end
      end
      ST_LEAD: begin
        if (tick_i) begin
          state_d = ST_SHIFT;
          sclk_d  = 1'b1;
          rise    = 1'b1;
        end
      end
      ST_SHIFT: begin
        if (tick_i) begin
          if (!sclk_q) begin
            sclk_d = 1'b1;
            rise   = 1'b1;
          end else begin
            sclk_d = 1'b0;
            if (bit_q == LAST_IDX) begin
              state_d = ST_TRAIL;
            end else begin
              bit_d   = bit_q + 1'b1;
              shift_o = 1'b1;
            end
          end
        end
      end
      ST_TRAIL: begin
        if (tick_i) begin
          state_d  = ST_IDLE;
          csn_d    = 1'b1;
          done_d   = 1'b1;
          commit_o = rd_q;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign sample_o = rise && rd_q && (bit_q >= DATA_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sclk_q  <= 1'b0;
      csn_q   <= 1'b1;
      done_q  <= 1'b0;
      rd_q    <= 1'b0;
      bit_q   <= '0;
    end else begin
      state_q <= state_d;
      sclk_q  <= sclk_d;
      csn_q   <= csn_d;
      done_q  <= done_d;
      rd_q    <= rd_d;
      bit_q   <= bit_d;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign sclk_o = sclk_q;
  assign csn_o  = csn_q;

endmodule

// File: rtl/lsb_spi_master.sv
module lsb_spi_master #(
  parameter int ADDR_W  = 14,
  parameter int DATA_W  = 8,
  parameter int CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sclk_o,
  output logic              csn_o,
  output logic              mosi_o,
  input  logic              miso_i
);

  localparam int HALF       = (CLK_DIV < 2) ? 1 : CLK_DIV / 2;
  localparam int HDR_BITS   = ADDR_W + 2;
  localparam int FRAME_BITS = HDR_BITS + DATA_W;

  logic tick, load, shift, sample, commit, busy;

  lsb_spi_halftick #(.HALF(HALF)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (busy),
    .tick_o (tick)
  );

  lsb_spi_ctrl #(.FRAME_BITS(FRAME_BITS), .HDR_BITS(HDR_BITS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req_i),
    .rd_i     (rd_i),
    .tick_i   (tick),
    .busy_o   (busy),
    .done_o   (done_o),
    .sclk_o   (sclk_o),
    .csn_o    (csn_o),
    .load_o   (load),
    .shift_o  (shift),
    .sample_o (sample),
    .commit_o (commit)
  );

  lsb_spi_txshift #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .shift_i (shift),
    .rd_i    (rd_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .mosi_o  (mosi_o)
  );

  lsb_spi_rxcap #(.DATA_W(DATA_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample_i (sample),
    .commit_i (commit),
    .miso_i   (miso_i),
    .rdata_o  (rdata_o)
  );

  assign busy_o = busy;

endmodule

// File: rtl/lsb_spi_checker.sv
module lsb_spi_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              done_o,
  input logic              sclk_o,
  input logic              csn_o,
  input logic              mosi_o,
  input logic [DATA_W-1:0] rdata_o
);

  assert_sclk_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    csn_o |-> !sclk_o);

  assert_mosi_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && csn_o));

  assert_busy_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !csn_o);

  assert_rdata_only_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata_o) |-> done_o);

endmodule

bind lsb_spi_master lsb_spi_checker #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .sclk_o  (sclk_o),
  .csn_o   (csn_o),
  .mosi_o  (mosi_o),
  .rdata_o (rdata_o)
);

// File: tb/sim_lsb_spi_master.sv
module sim_lsb_spi_master;

  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int H          = DIV / 2;
  localparam int FB         = 24;
  localparam int DONE_J     = (2 * FB + 1) * H;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, rd;
  logic [13:0] addr;
  logic [7:0]  wdata;
  logic        busy, done, sclk, csn, mosi, miso;
  logic [7:0]  rdata;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 1'b0;
  logic [7:0] slave_byte = 8'h00;
  int falls = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lsb_spi_master #(.ADDR_W(14), .DATA_W(8), .CLK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .busy_o(busy), .done_o(done), .rdata_o(rdata),
    .sclk_o(sclk), .csn_o(csn), .mosi_o(mosi), .miso_i(miso)
  );

  // Peripheral model: presents byte bit k after the (16+k)th falling edge.
  initial miso = 1'b1;
  always @(negedge csn) begin
    falls = 0;
    miso  = 1'b1;
  end
  always @(negedge sclk) begin
    falls = falls + 1;
    if (falls >= 16 && falls < 24) miso = slave_byte[falls-16];
    else                           miso = 1'b1;
  end

  // Reference model: cycle count since the accepting edge.
  bit         m_act;
  int         m_j;
  logic       m_rd;
  logic [13:0] m_addr;
  logic [7:0] m_wd, m_sb, m_rdata;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 1'b0; m_j = 0; m_rd = 1'b0; m_addr = '0;
      m_wd = '0; m_sb = '0; m_rdata = '0;
    end else begin
      if (!(m_act && m_j < DONE_J) && req) begin
        m_act = 1'b1; m_j = 0; m_rd = rd; m_addr = addr;
        m_wd = wdata; m_sb = slave_byte;
      end else if (m_act) begin
        if (m_j == DONE_J) m_act = 1'b0;
        else begin
          m_j = m_j + 1;
          if (m_j == DONE_J && m_rd) m_rdata = m_sb;
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  function automatic logic exp_bit(input int b);
    if (b == 0)       return m_rd;
    else if (b <= 14) return m_addr[b-1];
    else if (b == 15) return 1'b0;
    else              return m_rd ? 1'b0 : m_wd[b-16];
  endfunction

  function automatic string bit_tag(input int b);
    if (b == 0)       return "R2 flag bit";
    else if (b <= 14) return "R3 address bit";
    else if (b == 15) return "R4 pad bit";
    else if (m_rd)    return "R6 read data-phase mosi";
    else              return "R5 write data bit";
  endfunction

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit   b_e, d_e, c_e, s_e;
      int   j;
      cycles++;
      j   = m_j;
      b_e = m_act && j < DONE_J;
      d_e = m_act && j == DONE_J;
      c_e = !b_e;
      s_e = m_act && j >= H && j < 2 * FB * H && (((j - H) / H) % 2 == 0);
      chk("R9 busy", busy, b_e);
      chk("R9 done", done, d_e);
      chk(b_e ? "R8 chip select" : "R7 chip select idle", csn, c_e);
      chk(b_e ? "R8 serial clock" : "R7 serial clock idle", sclk, s_e);
      chk(m_rd ? "R6 read data" : "R10 read data held", rdata, m_rdata);
      if (s_e) chk(bit_tag(j / (2 * H)), mosi, exp_bit(j / (2 * H)));
      if (cycles > 20000) begin
        errors++;
        $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  task automatic access(input logic r, input logic [13:0] a,
                        input logic [7:0] w, input logic [7:0] sb);
    @(negedge clk);
    slave_byte = sb; rd = r; addr = a; wdata = w; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    repeat (DONE_J + 3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; req = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 csn in reset", csn, 1);
    chk("R1 sclk in reset", sclk, 0);
    chk("R1 busy in reset", busy, 0);
    chk("R1 done in reset", done, 0);
    chk("R1 rdata in reset", rdata, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    access(1'b0, 14'h0001, 8'hA5, 8'h5A);   // R5 write, R10 miso ignored
    access(1'b1, 14'h2000, 8'hFF, 8'h3C);   // R6 read, R2 flag
    access(1'b0, 14'h3FFF, 8'hFF, 8'h00);   // R10 rdata keeps 3C
    chk("R10 rdata after write", rdata, 8'h3C);
    access(1'b1, 14'h0000, 8'h00, 8'h81);   // R3 all-zero address
    access(1'b1, 14'h1555, 8'h00, 8'hFF);   // R3/R4 alternating address

    // R9: request raised mid-transfer is ignored
    @(negedge clk);
    slave_byte = 8'h96; rd = 1'b1; addr = 14'h2AAA; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    repeat (30) @(negedge clk);
    rd = 1'b0; addr = 14'h0F0F; wdata = 8'h11; req = 1'b1;
    repeat (5) @(negedge clk);
    req = 1'b0;
    repeat (DONE_J) @(negedge clk);
    chk("R9 ignored request left read data", rdata, 8'h96);

    // R9: request held across done starts the next access at once
    @(negedge clk);
    slave_byte = 8'h47; rd = 1'b1; addr = 14'h0123; req = 1'b1;
    while (!done) @(negedge clk);
    rd = 1'b0; addr = 14'h3210; wdata = 8'hC3;
    @(negedge clk);
    req = 1'b0;
    chk("R9 back-to-back busy", busy, 1);
    repeat (DONE_J + 3) @(negedge clk);
    chk("R10 rdata after back-to-back write", rdata, 8'h47);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule